// File: doc/BRIEF.md
# Rate-Limited Interrupt Collector

This block gathers event indications from a group of monitored sources into one status word that clears when the host reads it. It also drives an active-low interrupt request toward that host. A six-bit enable register decides, for each enable-controlled source, whether its event counts as an interrupt. For the wake sources it also decides whether, in standby, the event instead becomes a one-cycle reset request for the system.

Sources come in two classes. A serial clock-count failure or a battery failure is timing-critical and pulls the request pin low on the next clock edge. Every other source is recorded in the status word at once. In normal mode, however, such a source only reaches the pin on the next watchdog period tick, so a chattering fault cannot flood the host with interrupts. A status read clears the word but keeps any event that lands in the same cycle. The read also forces the pin high for a fixed number of cycles, so that a request still outstanding after the read shows up as a new falling edge.

Top module: `irq_gather`

## Requirements
- R1: Each qualified event sets its status bit on the clock edge that samples it. The status bits are: 0 serial clock-count failure, 1 battery failure, 2 overtemperature, 3 ground shift, 4 CAN failure change, 5 LIN failure change, 6 supply failure, 7 wake-pin wake, 8 CAN wake, 9 LIN wake, 10 watchdog restart.
- R2: A cycle with `stat_rd` high clears the status word on the next edge. Events qualified in that same cycle stay set after the clear.
- R3: After a read, `irq_n` is held high for at least `N_GAP` cycles. An interrupt triggered in the read cycle or during the gap drives the pin low once the gap has elapsed.
- R4: A status bit 0 or 1 event drives `irq_n` low after one clock edge, in every mode.
- R5: In normal mode (`mode`=1), any event on bits 2 to 10 sets a pending flag and does not lower the pin. The next `wd_tick` lowers the pin and consumes the flag.
- R6: In standby (0), flash (2) or other (3) mode, events on bits 2 to 10 lower the pin after one edge.
- R7: `en_wr` loads `en_wdata` into the enable register, which is visible on `en_q` and resets to 0. The enable bits are: 5 CAN failure, 4 LIN failure, 3 wake pin, 2 watchdog restart, 1 CAN wake, 0 LIN wake.
- R8: With enable bit 5 (or 4) set, any change of `can_fail_vec` (or `lin_fail_vec`) from its previous value sets status bit 4 (or 5). With the enable bit clear, the change leaves the status word unchanged.
- R9: A falling edge on `wake_pin` while `wake_global_en` is high behaves as follows. With enable bit 3 set, it sets status bit 7 in modes 0, 1 and 2. With bit 3 clear, it requests a reset in standby and does nothing in other modes. With `wake_global_en` low, the edge has no effect.
- R10: With enable bit 1 (CAN) or bit 0 (LIN) set, a bus wake event sets status bit 8 or 9. This happens in standby, and in normal or flash mode when that transceiver's active input is low. With the enable bit clear, the event requests a reset in standby and does nothing otherwise.
- R11: `wd_ovf` clears enable bit 2, and the overflow takes priority over a write in the same cycle. While bit 2 is set, `wd_restart_ev` with `wd_off` high sets status bit 10.
- R12: `rst_req` is a one-cycle pulse on the edge after a reset-producing wake event.
- R13: Reset clears the status word, the enable register, the pending flag and the gap, leaves `irq_n` high and `rst_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 0 standby, 1 normal, 2 flash, 3 other |
| ev_sck_fail | input | 1 | Serial clock-count failure pulse (critical) |
| ev_batt_fail | input | 1 | Battery failure pulse (critical) |
| ev_overtemp | input | 1 | Overtemperature pulse |
| ev_gnd_shift | input | 1 | Ground shift pulse |
| ev_supply_fail | input | 1 | Supply failure pulse |
| can_fail_vec | input | NCF | CAN failure status vector |
| lin_fail_vec | input | NLF | LIN failure status vector |
| wake_pin | input | 1 | Local wake input, falling edge active |
| wake_global_en | input | 1 | Global enable for the wake input |
| can_wake_ev | input | 1 | CAN bus wake event pulse |
| lin_wake_ev | input | 1 | LIN bus wake event pulse |
| can_active | input | 1 | CAN transceiver already active |
| lin_active | input | 1 | LIN transceiver already active |
| wd_restart_ev | input | 1 | Watchdog restart pulse |
| wd_off | input | 1 | Watchdog is switched off |
| wd_tick | input | 1 | Watchdog period tick |
| wd_ovf | input | 1 | Watchdog overflow pulse |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | Enable register write data |
| stat_rd | input | 1 | Status read strobe |
| stat_q | output | 11 | Status word |
| en_q | output | 6 | Enable register contents |
| irq_n | output | 1 | Active-low interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Each source class is driven in normal, flash and standby mode. Critical events lower the pin at once in every mode, while non-critical ones wait for a watchdog tick only in normal mode. This separates the throttle from the critical path and from the mode decode. Reads are issued both alone and together with a new event, and the pin is watched for every cycle of the gap. This distinguishes a lost same-cycle event from a gap that is one cycle too short or too long. Wake sources are tried with the enable bit set and clear, with the transceiver active and idle, and with the global wake enable low, which tells the interrupt, reset and no-effect paths apart.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
   localparam int ST_W = 11;
   localparam int EN_W = 6;

   localparam int B_SCK  = 0;
   localparam int B_BAT  = 1;
   localparam int B_OVT  = 2;
   localparam int B_GND  = 3;
   localparam int B_CANF = 4;
   localparam int B_LINF = 5;
   localparam int B_SUP  = 6;
   localparam int B_WAKE = 7;
   localparam int B_CANW = 8;
   localparam int B_LINW = 9;
   localparam int B_WDR  = 10;

   localparam logic [ST_W-1:0] CRIT_MASK = ST_W'((1 << B_SCK) | (1 << B_BAT));

   localparam int EN_LINW = 0;
   localparam int EN_CANW = 1;
   localparam int EN_WDR  = 2;
   localparam int EN_WAKE = 3;
   localparam int EN_LINF = 4;
   localparam int EN_CANF = 5;

   typedef enum logic [1:0] {
      MD_STBY  = 2'd0,
      MD_NORM  = 2'd1,
      MD_FLASH = 2'd2,
      MD_OTHER = 2'd3
   } op_mode_t;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
   import irq_gather_pkg::*;
#(
   parameter int W = EN_W,
   parameter int SELF_CLR_BIT = EN_WDR
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         wd_ovf,
   output logic [W-1:0] en_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == SELF_CLR_BIT) begin : g_selfclr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      en_q[i] <= 1'b0;
            else if (wd_ovf) en_q[i] <= 1'b0;
            else if (wr)     en_q[i] <= wdata[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  en_q[i] <= 1'b0;
            else if (wr) en_q[i] <= wdata[i];
         end
      end
   end
endmodule

// File: rtl/irq_src_qual.sv
module irq_src_qual
   import irq_gather_pkg::*;
#(
   parameter int NCF = 2,
   parameter int NLF = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode,
   input  logic [EN_W-1:0] en,
   input  logic            sck_fail,
   input  logic            batt_fail,
   input  logic            overtemp,
   input  logic            gnd_shift,
   input  logic            supply_fail,
   input  logic [NCF-1:0]  can_fail_vec,
   input  logic [NLF-1:0]  lin_fail_vec,
   input  logic            wake_pin,
   input  logic            wake_gen,
   input  logic            can_wake,
   input  logic            lin_wake,
   input  logic            can_active,
   input  logic            lin_active,
   input  logic            wdr_ev,
   input  logic            wd_off,
   output logic [ST_W-1:0] ev_vec,
   output logic            rst_hit
);
   logic           wake_q;
   logic [NCF-1:0] canf_q;
   logic [NLF-1:0] linf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b1;
         canf_q <= '0;
         linf_q <= '0;
      end else begin
         wake_q <= wake_pin;
         canf_q <= can_fail_vec;
         linf_q <= lin_fail_vec;
      end
   end

   op_mode_t md;
   logic     stby, awake, wake_fall, canf_chg, linf_chg;

   assign md        = op_mode_t'(mode);
   assign stby      = (md == MD_STBY);
   assign awake     = (md == MD_NORM) || (md == MD_FLASH);
   assign wake_fall = wake_gen & wake_q & ~wake_pin;
   assign canf_chg  = |(can_fail_vec ^ canf_q);
   assign linf_chg  = |(lin_fail_vec ^ linf_q);

   always_comb begin
      ev_vec         = '0;
      rst_hit        = 1'b0;
      ev_vec[B_SCK]  = sck_fail;
      ev_vec[B_BAT]  = batt_fail;
      ev_vec[B_OVT]  = overtemp;
      ev_vec[B_GND]  = gnd_shift;
      ev_vec[B_SUP]  = supply_fail;
      ev_vec[B_CANF] = en[EN_CANF] & canf_chg;
      ev_vec[B_LINF] = en[EN_LINF] & linf_chg;
      ev_vec[B_WDR]  = en[EN_WDR] & wdr_ev & wd_off;
      if (wake_fall) begin
         if (en[EN_WAKE]) ev_vec[B_WAKE] = stby | awake;
         else if (stby)   rst_hit = 1'b1;
      end
      if (can_wake) begin
         if (en[EN_CANW]) ev_vec[B_CANW] = stby | (awake & ~can_active);
         else if (stby)   rst_hit = 1'b1;
      end
      if (lin_wake) begin
         if (en[EN_LINW]) ev_vec[B_LINW] = stby | (awake & ~lin_active);
         else if (stby)   rst_hit = 1'b1;
      end
   end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
   import irq_gather_pkg::*;
#(
   parameter int N_GAP = 4,
   parameter int W = ST_W,
   parameter logic [W-1:0] CRIT = CRIT_MASK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev_vec,
   input  logic         norm_mode,
   input  logic         wd_tick,
   input  logic         stat_rd,
   output logic [W-1:0] stat_q,
   output logic         irq_n
);
   logic pend_q, act_q, quiet;
   logic crit_hit, nc_hit, trig;

   assign crit_hit = |(ev_vec & CRIT);
   assign nc_hit   = |(ev_vec & ~CRIT);
   assign trig     = crit_hit | (nc_hit & ~norm_mode) | (pend_q & wd_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         stat_q <= (stat_rd ? '0 : stat_q) | ev_vec;
         pend_q <= (pend_q & ~wd_tick) | (nc_hit & norm_mode);
         act_q  <= stat_rd ? trig : (act_q | trig);
      end
   end

   if (N_GAP == 1) begin : g_gap1
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q <= 1'b0;
         else        hold_q <= stat_rd;
      end
      assign quiet = hold_q;
   end else begin : g_gapn
      localparam int GW = $clog2(N_GAP + 1);
      logic [GW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (stat_rd)       cnt_q <= GW'(N_GAP);
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign quiet = (cnt_q != '0);
   end

   assign irq_n = ~(act_q & ~quiet);
endmodule

// File: rtl/irq_gather.sv
module irq_gather
   import irq_gather_pkg::*;
#(
   parameter int NCF   = 2,
   parameter int NLF   = 2,
   parameter int N_GAP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             ev_sck_fail,
   input  logic             ev_batt_fail,
   input  logic             ev_overtemp,
   input  logic             ev_gnd_shift,
   input  logic             ev_supply_fail,
   input  logic [NCF-1:0]   can_fail_vec,
   input  logic [NLF-1:0]   lin_fail_vec,
   input  logic             wake_pin,
   input  logic             wake_global_en,
   input  logic             can_wake_ev,
   input  logic             lin_wake_ev,
   input  logic             can_active,
   input  logic             lin_active,
   input  logic             wd_restart_ev,
   input  logic             wd_off,
   input  logic             wd_tick,
   input  logic             wd_ovf,
   input  logic             en_wr,
   input  logic [EN_W-1:0]  en_wdata,
   input  logic             stat_rd,
   output logic [ST_W-1:0]  stat_q,
   output logic [EN_W-1:0]  en_q,
   output logic             irq_n,
   output logic             rst_req
);
   if (N_GAP < 1) begin : g_bad_gap
      $error("irq_gather: N_GAP must be at least 1");
   end
   if (NCF < 1 || NLF < 1) begin : g_bad_vec
      $error("irq_gather: failure vectors need at least one bit");
   end

   logic [ST_W-1:0] ev_vec;
   logic            rst_hit;

   irq_en_reg #(.W(EN_W), .SELF_CLR_BIT(EN_WDR)) u_en (
      .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(en_wdata),
      .wd_ovf(wd_ovf), .en_q(en_q)
   );

   irq_src_qual #(.NCF(NCF), .NLF(NLF)) u_qual (
      .clk(clk), .rst_n(rst_n), .mode(mode), .en(en_q),
      .sck_fail(ev_sck_fail), .batt_fail(ev_batt_fail),
      .overtemp(ev_overtemp), .gnd_shift(ev_gnd_shift),
      .supply_fail(ev_supply_fail),
      .can_fail_vec(can_fail_vec), .lin_fail_vec(lin_fail_vec),
      .wake_pin(wake_pin), .wake_gen(wake_global_en),
      .can_wake(can_wake_ev), .lin_wake(lin_wake_ev),
      .can_active(can_active), .lin_active(lin_active),
      .wdr_ev(wd_restart_ev), .wd_off(wd_off),
      .ev_vec(ev_vec), .rst_hit(rst_hit)
   );

   irq_throttle #(.N_GAP(N_GAP), .W(ST_W), .CRIT(CRIT_MASK)) u_thr (
      .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec),
      .norm_mode(mode == MD_NORM), .wd_tick(wd_tick),
      .stat_rd(stat_rd), .stat_q(stat_q), .irq_n(irq_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= rst_hit;
   end
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
   import irq_gather_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            stat_rd,
   input logic            wd_ovf,
   input logic            ev_sck_fail,
   input logic            irq_n,
   input logic            rst_req,
   input logic [1:0]      mode,
   input logic [ST_W-1:0] stat_q,
   input logic [ST_W-1:0] ev_vec,
   input logic [EN_W-1:0] en_q
);
   // R2
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> (stat_q == $past(ev_vec)));

   // R3
   gap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> irq_n);

   // R11
   wdr_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_ovf |=> !en_q[EN_WDR]);

   // R12
   rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(mode) == MD_STBY));

   // R4
   crit_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sck_fail |=> stat_q[B_SCK]);
endmodule

bind irq_gather irq_gather_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .wd_ovf(wd_ovf),
   .ev_sck_fail(ev_sck_fail), .irq_n(irq_n), .rst_req(rst_req),
   .mode(mode), .stat_q(stat_q), .ev_vec(ev_vec), .en_q(en_q)
);

// File: tb/sim_irq_gather.sv
`timescale 1ns/1ps
module sim_irq_gather;
   localparam int NCF = 2;
   localparam int NLF = 2;
   localparam int N_GAP = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic [1:0] mode = 2'd1;
   logic ev_sck_fail = 0, ev_batt_fail = 0, ev_overtemp = 0, ev_gnd_shift = 0, ev_supply_fail = 0;
   logic [NCF-1:0] can_fail_vec = '0;
   logic [NLF-1:0] lin_fail_vec = '0;
   logic wake_pin = 1, wake_global_en = 0, can_wake_ev = 0, lin_wake_ev = 0;
   logic can_active = 0, lin_active = 0, wd_restart_ev = 0, wd_off = 0;
   logic wd_tick = 0, wd_ovf = 0, en_wr = 0, stat_rd = 0;
   logic [5:0] en_wdata = '0;
   logic [10:0] stat_q;
   logic [5:0] en_q;
   logic irq_n, rst_req;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   irq_gather #(.NCF(NCF), .NLF(NLF), .N_GAP(N_GAP)) u0 (.*);

   // behavioural reference model
   logic [10:0] m_stat, e;
   logic [5:0]  m_en;
   logic        m_pend, m_act, m_rst, p_wake, r, fire, stby, awake;
   int          m_gap;
   logic [NCF-1:0] p_canf;
   logic [NLF-1:0] p_linf;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat = 0; m_en = 0; m_pend = 0; m_act = 0; m_gap = 0; m_rst = 0;
         p_wake = 1; p_canf = 0; p_linf = 0;
      end else begin
         e = 0; r = 0;
         stby = (mode == 0);
         awake = (mode == 1) || (mode == 2);
         e[0] = ev_sck_fail; e[1] = ev_batt_fail; e[2] = ev_overtemp;
         e[3] = ev_gnd_shift; e[6] = ev_supply_fail;
         if (m_en[5] && can_fail_vec != p_canf) e[4] = 1;
         if (m_en[4] && lin_fail_vec != p_linf) e[5] = 1;
         if (wake_global_en && p_wake && !wake_pin) begin
            if (m_en[3]) begin if (stby || awake) e[7] = 1; end
            else if (stby) r = 1;
         end
         if (can_wake_ev) begin
            if (m_en[1]) begin if (stby || (awake && !can_active)) e[8] = 1; end
            else if (stby) r = 1;
         end
         if (lin_wake_ev) begin
            if (m_en[0]) begin if (stby || (awake && !lin_active)) e[9] = 1; end
            else if (stby) r = 1;
         end
         if (m_en[2] && wd_restart_ev && wd_off) e[10] = 1;
         fire = (e[1:0] != 0) || ((e[10:2] != 0) && mode != 1) || (m_pend && wd_tick);
         if (wd_tick) m_pend = 0;
         if ((e[10:2] != 0) && mode == 1) m_pend = 1;
         if (stat_rd) begin
            m_stat = e; m_act = fire; m_gap = N_GAP;
         end else begin
            m_stat = m_stat | e;
            if (fire) m_act = 1;
            if (m_gap > 0) m_gap--;
         end
         m_rst = r;
         if (en_wr) m_en = en_wdata;
         if (wd_ovf) m_en[2] = 0;
         p_wake = wake_pin; p_canf = can_fail_vec; p_linf = lin_fail_vec;
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 model stat_q", stat_q, m_stat);
         check("R4 model irq_n", irq_n, !(m_act && m_gap == 0));
         check("R7 model en_q", en_q, m_en);
         check("R12 model rst_req", rst_req, m_rst);
      end
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_en(logic [5:0] v);
      en_wdata = v; en_wr = 1; tick(); en_wr = 0;
   endtask

   task automatic rd_clear();
      stat_rd = 1; tick(); stat_rd = 0; tick(N_GAP + 1);
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick();
      // R13 reset state
      check("R13 stat", stat_q, 0);
      check("R13 irq_n", irq_n, 1);
      check("R13 en", en_q, 0);
      check("R13 rst_req", rst_req, 0);

      // R7 enable write
      wr_en(6'h3F);
      check("R7 en_q", en_q, 6'h3F);

      // R1 R4 critical in normal mode
      ev_sck_fail = 1; tick(); ev_sck_fail = 0;
      check("R1 bit0", stat_q[0], 1);
      check("R4 irq low", irq_n, 0);

      // R2 R3 read releases
      stat_rd = 1; tick(); stat_rd = 0;
      check("R2 cleared", stat_q, 0);
      check("R3 released", irq_n, 1);
      tick(N_GAP + 1);

      // R5 throttled overtemp
      ev_overtemp = 1; tick(); ev_overtemp = 0;
      check("R5 recorded", stat_q[2], 1);
      check("R5 pin held", irq_n, 1);
      tick(3);
      check("R5 still held", irq_n, 1);
      wd_tick = 1; tick(); wd_tick = 0;
      check("R5 pin on tick", irq_n, 0);
      rd_clear();
      wd_tick = 1; tick(); wd_tick = 0;
      check("R5 pending consumed", irq_n, 1);

      // R2 R3 read with simultaneous battery failure
      stat_rd = 1; ev_batt_fail = 1; tick(); stat_rd = 0; ev_batt_fail = 0;
      check("R2 kept bit1", stat_q, 11'h002);
      for (int k = 1; k < N_GAP; k++) begin
         tick();
         check("R3 gap high", irq_n, 1);
      end
      tick();
      check("R3 fresh edge", irq_n, 0);
      rd_clear();

      // R6 flash mode immediate
      mode = 2;
      ev_gnd_shift = 1; tick(); ev_gnd_shift = 0;
      check("R6 flash immediate", irq_n, 0);
      check("R1 bit3", stat_q[3], 1);
      rd_clear();
      mode = 0;
      ev_supply_fail = 1; tick(); ev_supply_fail = 0;
      check("R6 standby immediate", irq_n, 0);
      rd_clear();

      // R8 failure vectors
      can_fail_vec = 2'b01; tick();
      check("R8 can change", stat_q[4], 1);
      rd_clear();
      wr_en(6'h2F);
      lin_fail_vec = 2'b10; tick();
      check("R8 lin disabled", stat_q, 0);
      check("R8 lin disabled pin", irq_n, 1);

      // R9 wake pin in standby
      wake_global_en = 1;
      wake_pin = 0; tick(); wake_pin = 1;
      check("R9 wake enabled", stat_q[7], 1);
      rd_clear();
      wr_en(6'h27);
      wake_pin = 0; tick(); wake_pin = 1;
      check("R12 rst pulse", rst_req, 1);
      check("R9 no status", stat_q[7], 0);
      tick();
      check("R12 pulse ends", rst_req, 0);
      wake_global_en = 0;
      wr_en(6'h2F);
      wake_pin = 0; tick(); wake_pin = 1;
      check("R9 global off", stat_q[7], 0);
      tick();

      // R10 bus wakes
      mode = 1; can_active = 1;
      can_wake_ev = 1; tick(); can_wake_ev = 0;
      check("R10 can active", stat_q[8], 0);
      can_active = 0;
      can_wake_ev = 1; tick(); can_wake_ev = 0;
      check("R10 can idle", stat_q[8], 1);
      wd_tick = 1; tick(); wd_tick = 0;
      rd_clear();
      mode = 0;
      wr_en(6'h2E);
      lin_wake_ev = 1; tick(); lin_wake_ev = 0;
      check("R10 lin reset", rst_req, 1);
      check("R10 lin no status", stat_q[9], 0);

      // R11 watchdog restart
      mode = 2; wd_off = 1;
      wd_restart_ev = 1; tick(); wd_restart_ev = 0;
      check("R11 restart irq", stat_q[10], 1);
      rd_clear();
      wd_ovf = 1; en_wdata = 6'h3F; en_wr = 1; tick(); wd_ovf = 0; en_wr = 0;
      check("R11 self clear", en_q[2], 0);
      wd_restart_ev = 1; tick(); wd_restart_ev = 0;
      check("R11 no irq", stat_q[10], 0);

      // R13 reset mid-run
      ev_sck_fail = 1; tick(); ev_sck_fail = 0;
      rst_n = 0; tick();
      check("R13 stat after reset", stat_q, 0);
      check("R13 irq after reset", irq_n, 1);
      check("R13 en after reset", en_q, 0);
      tick(2); rst_n = 1; tick(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule